// File: doc/BRIEF.md
# NOR Flash Array Program/Erase Engine

This block owns the byte array behind a serial NOR flash model and carries out the two write-side operations that a command sequencer hands it. A byte-program request names an address and a data byte. An erase request names an erase kind (small, block, sector or whole chip) and a start offset. The engine applies NOR rules to the array and reports its progress and any faults through single-cycle pulses and a busy level. A separate registered read port lets the sequencer fetch any byte.

Programming normally clears bits only: the stored byte becomes the AND of old and new. A build parameter instead lets a write replace the old byte directly, which suits an EEPROM-like device. Erasing fills a range with 0xFF, one byte per clock, starting at the given offset. The erase length depends on the kind: a small erase and a block erase have fixed lengths, a sector erase covers the configured sector size, and a chip erase covers the whole array. Two capability parameters state whether the small and block sizes are supported. Reset runs the same fill over the whole array, so every byte reads 0xFF once the reset sweep is over.

Top module: `flashEngine`

## Requirements
- R1: After reset, `busy` stays high while the array is swept, and `done` stays low throughout. When `busy` falls, every address reads 0xFF.
- R2: With `DIRECT_WRITE`=0, a byte program stores old AND new.
- R3: With `DIRECT_WRITE`=1, a byte program stores the new byte unchanged.
- R4: A program accepted while `writeEnable` is low is still stored. `errProtect` pulses high for one cycle in the cycle after the request.
- R5: `errZeroToOne` pulses in the cycle after a program whose data would turn a stored 0 bit into 1, that is when ((old XOR new) AND new) is nonzero. Otherwise it stays low.
- R6: An erase fills addresses start..start+len-1 with 0xFF and leaves the bytes on either side untouched. The `eraseKind` encodings are: 0 is small (`SMALL_ERASE_BYTES`), 1 is block (`BLOCK_ERASE_BYTES`), 2 is sector (`SECTOR_BYTES`), and 3 is chip (the whole array, with the offset ignored).
- R7: An erase requested while `writeEnable` is low is discarded. `busy` stays low, the array is unchanged, and `errProtect` pulses in the next cycle.
- R8: An erase of kind 0 when `CAN_ERASE_SMALL`=0, or of kind 1 when `CAN_ERASE_BLOCK`=0, pulses `errSize` in the next cycle whatever the state of `writeEnable`. The erase still runs when `writeEnable` is high.
- R9: An accepted erase holds `busy` high for exactly one cycle per erased byte. `done` pulses for one cycle in the cycle where `busy` falls.
- R10: While `busy` is high, program and erase requests are ignored. They change no array byte and raise no flag.
- R11: An erase range that would pass the last address is clipped at the last address.
- R12: When a program and an erase arrive in the same idle cycle, both are accepted. The program is written first, and the erase then overwrites it if the address lies inside the erase range.
- R13: `rdData` shows the byte at `rdAddr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low; starts the fill sweep |
| writeEnable | input | 1 | Write-enable level from the status logic |
| progValid | input | 1 | Byte-program request |
| progAddr | input | ADDR_W | Program address |
| progData | input | 8 | Program data byte |
| eraseValid | input | 1 | Erase request |
| eraseKind | input | 2 | 0 small, 1 block, 2 sector, 3 chip |
| eraseAddr | input | ADDR_W | Erase start offset |
| rdAddr | input | ADDR_W | Read-port address |
| rdData | output | 8 | Read-port data, one-cycle latency |
| busy | output | 1 | Reset sweep or erase in progress |
| done | output | 1 | One-cycle pulse when an erase ends |
| errProtect | output | 1 | Pulse: request made with write enable low |
| errSize | output | 1 | Pulse: erase size not supported by the device |
| errZeroToOne | output | 1 | Pulse: program tried to set a cleared bit |

## Verification
A byte program and an erase can both be accepted in the same idle cycle. The program writes in that cycle and the fill starts writing on the next one. The bench provokes this by raising `progValid` and `eraseValid` on the same edge, once with the program address inside the erase range and once outside it. It then reads both bytes back through the read port. The byte inside the range must read 0xFF. The byte outside must hold the programmed value, with `done` and the busy count matching the clipped range length.

// File: rtl/flashEngPkg.sv
package flashEngPkg;

  typedef enum logic [1:0] {
    KIND_SMALL  = 2'd0,
    KIND_BLOCK  = 2'd1,
    KIND_SECTOR = 2'd2,
    KIND_CHIP   = 2'd3
  } eraseKindT;

  typedef enum logic [1:0] {
    ST_SWEEP = 2'd0,
    ST_IDLE  = 2'd1,
    ST_FILL  = 2'd2
  } engStateT;

  typedef struct packed {
    logic progWrite;
    logic loadRange;
    logic fillStep;
  } ctrlStrobeT;

endpackage

// File: rtl/flashEngCtrl.sv
module flashEngCtrl
  import flashEngPkg::*;
#(
  parameter bit CAN_ERASE_SMALL = 1'b1,
  parameter bit CAN_ERASE_BLOCK = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       writeEnable,
  input  logic       progValid,
  input  logic       eraseValid,
  input  logic [1:0] eraseKind,
  input  logic       fillLast,
  output ctrlStrobeT strobe,
  output logic       busy,
  output logic       done,
  output logic       errProtect,
  output logic       errSize
);

  engStateT state, stateNext;
  logic     idle;
  logic     sizeBad;

  assign idle = (state == ST_IDLE);

  // Capability check is chosen per build
  generate
    if (CAN_ERASE_SMALL && CAN_ERASE_BLOCK) begin : gCapAll
      assign sizeBad = 1'b0;
    end else begin : gCapSome
      assign sizeBad = ((eraseKind == KIND_SMALL) && !CAN_ERASE_SMALL) ||
                       ((eraseKind == KIND_BLOCK) && !CAN_ERASE_BLOCK);
    end
  endgenerate

  always_comb begin
    strobe.progWrite = idle && progValid;
    strobe.loadRange = idle && eraseValid && writeEnable;
    strobe.fillStep  = !idle;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_SWEEP: if (fillLast) stateNext = ST_IDLE;
      ST_IDLE:  if (strobe.loadRange) stateNext = ST_FILL;
      ST_FILL:  if (fillLast) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_SWEEP;
      done       <= 1'b0;
      errProtect <= 1'b0;
      errSize    <= 1'b0;
    end else begin
      state      <= stateNext;
      done       <= (state == ST_FILL) && fillLast;
      errProtect <= idle && (progValid || eraseValid) && !writeEnable;
      errSize    <= idle && eraseValid && sizeBad;
    end
  end

  assign busy = !idle;

endmodule

// File: rtl/flashEngDatapath.sv
module flashEngDatapath
  import flashEngPkg::*;
#(
  parameter int SECTOR_BYTES      = 512,
  parameter int SECTOR_COUNT      = 4,
  parameter int SMALL_ERASE_BYTES = 64,
  parameter int BLOCK_ERASE_BYTES = 256,
  parameter bit DIRECT_WRITE      = 1'b0,
  localparam int ARRAY_BYTES      = SECTOR_BYTES * SECTOR_COUNT,
  localparam int ADDR_W           = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [7:0]        progData,
  input  logic [1:0]        eraseKind,
  input  logic [ADDR_W-1:0] eraseAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              fillLast,
  output logic              zeroToOne
);

  localparam int LAST = ARRAY_BYTES - 1;

  logic [7:0]        mem [ARRAY_BYTES];
  logic [ADDR_W-1:0] fillPtr, fillEnd;
  logic [7:0]        oldByte, newByte;
  logic [31:0]       spanLen, rangeEnd;
  logic [ADDR_W-1:0] rangeStart, rangeStop;

  assign oldByte = mem[progAddr];

  generate
    if (DIRECT_WRITE) begin : gOverwrite
      assign newByte = progData;
    end else begin : gClearOnly
      assign newByte = oldByte & progData;
    end
  endgenerate

  // Erase range: start plus kind length, clipped at the last byte
  always_comb begin
    case (eraseKind)
      KIND_SMALL:  spanLen = 32'(SMALL_ERASE_BYTES);
      KIND_BLOCK:  spanLen = 32'(BLOCK_ERASE_BYTES);
      KIND_SECTOR: spanLen = 32'(SECTOR_BYTES);
      default:     spanLen = 32'(ARRAY_BYTES);
    endcase
    rangeStart = (eraseKind == KIND_CHIP) ? '0 : eraseAddr;
    rangeEnd   = 32'(rangeStart) + spanLen - 32'd1;
    rangeStop  = (rangeEnd > 32'(LAST)) ? ADDR_W'(LAST) : rangeEnd[ADDR_W-1:0];
  end

  assign fillLast = (fillPtr == fillEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillPtr <= '0;
      fillEnd <= ADDR_W'(LAST);
    end else if (strobe.loadRange) begin
      fillPtr <= rangeStart;
      fillEnd <= rangeStop;
    end else if (strobe.fillStep && !fillLast) begin
      fillPtr <= fillPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillStep) begin
      mem[fillPtr] <= 8'hFF;
    end else if (strobe.progWrite) begin
      mem[progAddr] <= newByte;
    end
    rdData <= mem[rdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) zeroToOne <= 1'b0;
    else       zeroToOne <= strobe.progWrite && (|((oldByte ^ progData) & progData));
  end

endmodule

// File: rtl/flashEngine.sv
module flashEngine
  import flashEngPkg::*;
#(
  parameter int SECTOR_BYTES      = 512,
  parameter int SECTOR_COUNT      = 4,
  parameter int SMALL_ERASE_BYTES = 64,
  parameter int BLOCK_ERASE_BYTES = 256,
  parameter bit CAN_ERASE_SMALL   = 1'b1,
  parameter bit CAN_ERASE_BLOCK   = 1'b0,
  parameter bit DIRECT_WRITE      = 1'b0,
  localparam int ADDR_W           = $clog2(SECTOR_BYTES * SECTOR_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              writeEnable,
  input  logic              progValid,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [7:0]        progData,
  input  logic              eraseValid,
  input  logic [1:0]        eraseKind,
  input  logic [ADDR_W-1:0] eraseAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              done,
  output logic              errProtect,
  output logic              errSize,
  output logic              errZeroToOne
);

  ctrlStrobeT strobe;
  logic       fillLast;

  flashEngCtrl #(
    .CAN_ERASE_SMALL(CAN_ERASE_SMALL),
    .CAN_ERASE_BLOCK(CAN_ERASE_BLOCK)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .writeEnable(writeEnable),
    .progValid  (progValid),
    .eraseValid (eraseValid),
    .eraseKind  (eraseKind),
    .fillLast   (fillLast),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done),
    .errProtect (errProtect),
    .errSize    (errSize)
  );

  flashEngDatapath #(
    .SECTOR_BYTES     (SECTOR_BYTES),
    .SECTOR_COUNT     (SECTOR_COUNT),
    .SMALL_ERASE_BYTES(SMALL_ERASE_BYTES),
    .BLOCK_ERASE_BYTES(BLOCK_ERASE_BYTES),
    .DIRECT_WRITE     (DIRECT_WRITE)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .progAddr (progAddr),
    .progData (progData),
    .eraseKind(eraseKind),
    .eraseAddr(eraseAddr),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .fillLast (fillLast),
    .zeroToOne(errZeroToOne)
  );

endmodule

// File: rtl/flashEngineChecker.sv
module flashEngineChecker (
  input logic clk,
  input logic rstN,
  input logic writeEnable,
  input logic progValid,
  input logic eraseValid,
  input logic busy,
  input logic done,
  input logic errProtect,
  input logic errSize,
  input logic errZeroToOne
);

  a_r9_busy_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && eraseValid && writeEnable) |=> busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  a_r7_protect_discard: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && eraseValid && !writeEnable) |=> (!busy && errProtect));

  a_r5_flag_source: assert property (@(posedge clk) disable iff (!rstN)
    errZeroToOne |-> $past(progValid && !busy));

  a_r8_size_source: assert property (@(posedge clk) disable iff (!rstN)
    errSize |-> $past(eraseValid && !busy));

  a_r10_protect_idle_only: assert property (@(posedge clk) disable iff (!rstN)
    errProtect |-> $past(!busy && !writeEnable));

endmodule

bind flashEngine flashEngineChecker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .writeEnable (writeEnable),
  .progValid   (progValid),
  .eraseValid  (eraseValid),
  .busy        (busy),
  .done        (done),
  .errProtect  (errProtect),
  .errSize     (errSize),
  .errZeroToOne(errZeroToOne)
);

// File: tb/sim_flashEngine.sv
module sim_flashEngine;

  localparam int SECT   = 512;
  localparam int NSECT  = 4;
  localparam int SMALL  = 64;
  localparam int BLOCK  = 256;
  localparam int BYTES  = SECT * NSECT;
  localparam int LASTA  = BYTES - 1;
  localparam int AW     = $clog2(BYTES);
  localparam bit CAPS   = 1'b1;
  localparam bit CAPB   = 1'b0;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          writeEnable = 1'b0;
  logic          progValid = 1'b0;
  logic [AW-1:0] progAddr = '0;
  logic [7:0]    progData = '0;
  logic          eraseValid = 1'b0;
  logic [1:0]    eraseKind = '0;
  logic [AW-1:0] eraseAddr = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0]    rdDataA, rdDataB;
  logic          busy, done, errProtect, errSize, errZeroToOne;
  logic          busyB, doneB, errProtectB, errSizeB, errZeroToOneB;

  int vectors = 0;
  int fails = 0;
  logic [7:0] modelA [BYTES];
  logic [7:0] modelB [BYTES];

  always #4 clk = ~clk;

  flashEngine u0 (
    .clk(clk), .rstN(rstN), .writeEnable(writeEnable),
    .progValid(progValid), .progAddr(progAddr), .progData(progData),
    .eraseValid(eraseValid), .eraseKind(eraseKind), .eraseAddr(eraseAddr),
    .rdAddr(rdAddr), .rdData(rdDataA), .busy(busy), .done(done),
    .errProtect(errProtect), .errSize(errSize), .errZeroToOne(errZeroToOne)
  );

  flashEngine #(.DIRECT_WRITE(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .writeEnable(writeEnable),
    .progValid(progValid), .progAddr(progAddr), .progData(progData),
    .eraseValid(eraseValid), .eraseKind(eraseKind), .eraseAddr(eraseAddr),
    .rdAddr(rdAddr), .rdData(rdDataB), .busy(busyB), .done(doneB),
    .errProtect(errProtectB), .errSize(errSizeB), .errZeroToOne(errZeroToOneB)
  );

  task automatic checkEq(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int spanOf(int kind);
    case (kind)
      0: return SMALL;
      1: return BLOCK;
      2: return SECT;
      default: return BYTES;
    endcase
  endfunction

  function automatic int stopOf(int kind, int addr);
    int s = (kind == 3) ? 0 : addr;
    int e = s + spanOf(kind) - 1;
    return (e > LASTA) ? LASTA : e;
  endfunction

  task automatic modelFill(int kind, int addr);
    int s = (kind == 3) ? 0 : addr;
    for (int i = s; i <= stopOf(kind, addr); i++) begin
      modelA[i] = 8'hFF;
      modelB[i] = 8'hFF;
    end
  endtask

  task automatic readBoth(string req, int addr);
    rdAddr = AW'(addr);
    @(negedge clk);
    checkEq({req, " u0"}, rdDataA, modelA[addr]);
    checkEq({req, " u1 (R3)"}, rdDataB, modelB[addr]);
  endtask

  task automatic doProg(int a, int d, bit we);
    bit expZ = ((modelA[a] ^ d) & d) != 0;
    modelA[a] = modelA[a] & 8'(d);
    modelB[a] = 8'(d);
    writeEnable = we; progAddr = AW'(a); progData = 8'(d); progValid = 1'b1;
    @(negedge clk);
    progValid = 1'b0;
    checkEq("R4 errProtect", errProtect, !we);
    checkEq("R5 errZeroToOne", errZeroToOne, expZ);
  endtask

  task automatic waitErase(string req, int expCnt);
    int cnt = 0;
    while (busy && cnt < BYTES + 8) begin
      cnt++;
      @(negedge clk);
    end
    checkEq({req, " busy cycles (R9)"}, cnt, expCnt);
    checkEq({req, " done pulse (R9)"}, done, 1);
  endtask

  task automatic doErase(int kind, int addr, bit we);
    bit expS = (kind == 0 && !CAPS) || (kind == 1 && !CAPB);
    int s = (kind == 3) ? 0 : addr;
    writeEnable = we; eraseKind = 2'(kind); eraseAddr = AW'(addr); eraseValid = 1'b1;
    @(negedge clk);
    eraseValid = 1'b0;
    checkEq("R8 errSize", errSize, expS);
    checkEq("R7 errProtect", errProtect, !we);
    if (we) begin
      waitErase("R6", stopOf(kind, addr) - s + 1);
      modelFill(kind, addr);
    end else begin
      checkEq("R7 busy stays low", busy, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int sawDone;
    void'($urandom(32'd2024));
    for (int i = 0; i < BYTES; i++) begin
      modelA[i] = 8'hFF;
      modelB[i] = 8'hFF;
    end
    repeat (3) @(negedge clk);
    checkEq("R1 busy in reset", busy, 1);
    rstN = 1'b1;
    sawDone = 0;
    while (busy) begin
      if (done) sawDone = 1;
      @(negedge clk);
    end
    checkEq("R1 no done after sweep", sawDone | done, 0);
    for (int i = 0; i < BYTES; i++) readBoth("R1 swept", i);

    // R2 / R3 / R5: clear-only versus overwrite
    doProg(10, 8'hA5, 1'b1);
    doProg(10, 8'h3C, 1'b1);
    readBoth("R2 and R13", 10);
    // R4: write-protected program is still stored
    doProg(20, 8'h0F, 1'b0);
    readBoth("R4 stored", 20);

    // R6: small erase at unaligned offset, neighbours kept
    doProg(4, 8'h00, 1'b1);
    doProg(30, 8'h00, 1'b1);
    doProg(69, 8'h00, 1'b1);
    doErase(0, 5, 1'b1);
    readBoth("R6 before range", 4);
    readBoth("R6 in range", 30);
    readBoth("R6 after range", 69);

    // R8: unsupported block size still runs; and with protect on
    doProg(400, 8'h11, 1'b1);
    doErase(1, 300, 1'b1);
    readBoth("R8 erased", 400);
    doProg(400, 8'h22, 1'b1);
    doErase(1, 300, 1'b0);
    readBoth("R8 protected", 400);

    // R7: protected sector erase discarded
    doErase(2, 0, 1'b0);
    readBoth("R7 unchanged", 10);

    // R11: clip at the last byte
    doProg(LASTA, 8'h00, 1'b1);
    doErase(2, 2000, 1'b1);
    readBoth("R11 last byte", LASTA);

    // R12: program and erase in the same cycle
    for (int k = 0; k < 2; k++) begin
      int pa = (k == 0) ? 100 : 500;
      writeEnable = 1'b1;
      progAddr = AW'(pa); progData = 8'h00; progValid = 1'b1;
      eraseKind = 2'd0; eraseAddr = AW'(90); eraseValid = 1'b1;
      modelA[pa] = modelA[pa] & 8'h00;
      modelB[pa] = 8'h00;
      @(negedge clk);
      progValid = 1'b0; eraseValid = 1'b0;
      waitErase("R12", SMALL);
      modelFill(0, 90);
      readBoth("R12 readback", pa);
    end

    // R10: requests during busy ignored
    writeEnable = 1'b1; eraseKind = 2'd2; eraseAddr = '0; eraseValid = 1'b1;
    @(negedge clk);
    eraseValid = 1'b0;
    modelFill(2, 0);
    repeat (3) @(negedge clk);
    writeEnable = 1'b0;
    progAddr = AW'(1000); progData = 8'h00; progValid = 1'b1;
    eraseKind = 2'd3; eraseValid = 1'b1;
    @(negedge clk);
    progValid = 1'b0; eraseValid = 1'b0;
    checkEq("R10 errProtect quiet", errProtect, 0);
    checkEq("R10 errZeroToOne quiet", errZeroToOne, 0);
    checkEq("R10 errSize quiet", errSize, 0);
    waitErase("R10", SECT - 4);
    readBoth("R10 byte untouched", 1000);
    readBoth("R10 chip not erased", 500);

    // Random mix against the model
    for (int n = 0; n < 80; n++) begin
      int a = $urandom_range(LASTA, 0);
      bit we = ($urandom_range(3, 0) != 0);
      if ($urandom_range(4, 0) == 0) doErase(0, a, we);
      else doProg(a, $urandom_range(255, 0), we);
    end
    for (int n = 0; n < 120; n++) readBoth("R2 random", $urandom_range(LASTA, 0));

    // R6: chip erase ignores offset
    doErase(3, 700, 1'b1);
    for (int n = 0; n < 16; n++) readBoth("R6 chip", $urandom_range(LASTA, 0));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule